// File: doc/BRIEF.md
# Relocation and Limit Address Guard

This block sits between a processor core and its memory path. It turns each logical address the core issues into a physical address, and it checks that address with two registers. The relocation register holds a physical base, and the limit register holds the size of the legal user window. When the core runs in user mode, a logical address `a` is legal only if `a < L`, where `L` is the limit register. A legal address leaves the block as `base + a`. An illegal one comes back as a trap and gives no address. When the core runs in kernel mode, the address goes through unchanged and is not checked.

Reads and writes of the two registers use the same request channel as memory accesses, with an operation code. Only kernel-mode requests may change the registers. A user-mode attempt comes back as a privilege trap and leaves both registers as they were.

Requests use a valid/ready handshake. Each accepted request produces exactly one response in the next cycle, held in a one-entry output register. The response carries the physical address, a trap flag and a cause code.

Top module: `reloc_guard`

## Requirements
- R1: After reset, no response is pending, `req_ready` is 1, and base and limit are both 0. Because the limit is 0, every user-mode access traps until kernel mode programs the limit.
- R2: A user-mode access (op 0) with `addr < limit` responds with `rsp_addr = (base + addr) mod 2^PW`, `rsp_trap = 0` and cause 0.
- R3: A user-mode access with `addr >= limit` (unsigned; an address equal to the limit is a violation) responds with `rsp_trap = 1`, cause 1 (range) and `rsp_addr = 0`.
- R4: A kernel-mode access responds with `rsp_addr` equal to the zero-extended logical address and no trap, whatever the base and limit hold.
- R5: A kernel-mode op 1 loads base from `req_wdata[PW-1:0]`, and a kernel-mode op 2 loads limit from `req_wdata[AW:0]`. The new value applies from the next accepted request. The response has no trap and `rsp_addr = 0`.
- R6: A user-mode op 1 or op 2 responds with trap cause 2 (privilege) and `rsp_addr = 0`, and it leaves base and limit unchanged.
- R7: Op 3 is reserved. In either mode it responds with trap cause 3 and `rsp_addr = 0`, and it changes no register.
- R8: `req_ready = !rsp_valid || rsp_ready`. The response to a request accepted at a clock edge is visible right after that edge. While `rsp_valid && !rsp_ready`, the response holds stable.
- R9: `rsp_trap` is 1 exactly when `rsp_cause` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 access, 1 set base, 2 set limit, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_addr | input | AW (16) | Logical address for op 0 |
| req_wdata | input | PW (20) | New register value for op 1 and op 2 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | PW (20) | Physical address, 0 for traps and register writes |
| rsp_trap | output | 1 | Request was refused |
| rsp_cause | output | 2 | 0 none, 1 range, 2 privilege, 3 reserved op |

## Verification
A wrong base shows up as a wrong `rsp_addr` on the first legal user access after the register is corrupted. A wrong limit shows up as a trap where none was due, or a missing one, on the first user access that falls between the true limit and the corrupted one. Both faults are visible one cycle after that request is accepted. Directed accesses at `limit-1`, at `limit` and at `limit+1`, and a base near the top of the physical space, expose off-by-one and wrap faults. A slip in the output register or the ready logic shows up in the same cycle as the stall, as a changed held response or a wrong `req_ready`.

// File: rtl/reloc_guard_pkg.sv
// Package: shared encodings for the relocation and limit address guard.
// Assumes: operation and cause codes are fixed, because the core and the
// trap handler decode them.
package reloc_guard_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS    = 2'd0,
        OP_SET_BASE  = 2'd1,
        OP_SET_LIMIT = 2'd2,
        OP_RESERVED  = 2'd3
    } rg_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RANGE = 2'd1,
        CAUSE_PRIV  = 2'd2,
        CAUSE_OP    = 2'd3
    } rg_cause_e;

endpackage

// File: rtl/rg_bound_regs.sv
// Module: rg_bound_regs
// Holds the relocation base and the user-window limit.
// Assumes: the write strobes are already qualified for privilege and for
// handshake acceptance, and at most one strobe is active per cycle.
module rg_bound_regs #(
    parameter int PW = 20,
    parameter int LW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_base,
    input  logic          set_limit,
    input  logic [PW-1:0] new_value,
    output logic [PW-1:0] base_q,
    output logic [LW-1:0] limit_q
);

    // Base register: cleared by reset, loaded on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (set_base) begin
            base_q <= new_value;
        end
    end

    // Limit register: cleared by reset, loaded from the low bits of the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (set_limit) begin
            limit_q <= new_value[LW-1:0];
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_base && set_limit)); // R5

endmodule

// File: rtl/rg_xlate.sv
// Module: rg_xlate
// Combinational decision for one request: physical address, cause, and
// register-write strobes.
// Assumes: PW > AW, so that the zero-extension and the sum fit in the
// physical width. The caller gates the strobes with the handshake.
module rg_xlate
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20,
    parameter int LW = AW + 1
) (
    input  logic [1:0]    op,
    input  logic          user,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] base,
    input  logic [LW-1:0] limit,
    output logic [PW-1:0] phys,
    output logic [1:0]    cause,
    output logic          want_base,
    output logic          want_limit
);

    localparam int EXT = PW - AW;

    logic [PW-1:0] addr_ext;
    logic [PW-1:0] reloc_sum;
    logic          in_window;

    // Zero-extend the logical address to the physical width.
    generate
        if (EXT > 0) begin : g_ext
            assign addr_ext = {{EXT{1'b0}}, addr};
        end else begin : g_same
            assign addr_ext = addr[PW-1:0];
        end
    endgenerate

    // Relocated address; it wraps modulo 2^PW.
    assign reloc_sum = base + addr_ext;

    // Unsigned window test; an address equal to the limit is outside.
    assign in_window = ({1'b0, addr} < limit);

    // Decide the response and the write strobes for each operation and mode.
    always_comb begin
        phys       = '0;
        cause      = CAUSE_NONE;
        want_base  = 1'b0;
        want_limit = 1'b0;
        unique case (rg_op_e'(op))
            OP_ACCESS: begin
                if (!user) begin
                    phys = addr_ext;
                end else if (in_window) begin
                    phys = reloc_sum;
                end else begin
                    cause = CAUSE_RANGE;
                end
            end
            OP_SET_BASE: begin
                if (user) cause = CAUSE_PRIV;
                else      want_base = 1'b1;
            end
            OP_SET_LIMIT: begin
                if (user) cause = CAUSE_PRIV;
                else      want_limit = 1'b1;
            end
            default: begin
                cause = CAUSE_OP;
            end
        endcase
    end

endmodule

// File: rtl/rg_resp_reg.sv
// Module: rg_resp_reg
// One-entry response register with a valid/ready handshake on both sides.
// Assumes: load is high only when the upstream handshake completes.
module rg_resp_reg #(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] in_addr,
    input  logic [1:0]    in_cause,
    output logic          can_take,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [PW-1:0] rsp_addr,
    output logic          rsp_trap,
    output logic [1:0]    rsp_cause
);

    // Space is free when the slot is empty or is being drained now.
    assign can_take = !rsp_valid || rsp_ready;

    // Valid flag: set by a load, cleared when the consumer drains the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else if (load) begin
            rsp_valid <= 1'b1;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // Payload: captured only on a load, so it holds while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr  <= '0;
            rsp_trap  <= 1'b0;
            rsp_cause <= '0;
        end else if (load) begin
            rsp_addr  <= in_addr;
            rsp_trap  <= (in_cause != 2'd0);
            rsp_cause <= in_cause;
        end
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr)
        && $stable(rsp_cause) && $stable(rsp_trap)); // R8
    AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_take); // R8

endmodule

// File: rtl/reloc_guard.sv
// Module: reloc_guard (top)
// Translates and guards each logical address with a relocation base and a
// user-window limit, and serves privileged updates of both registers.
// Assumes: one request per cycle at most. A response follows each accepted
// request by one cycle.
module reloc_guard
    import reloc_guard_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_user,
    input  logic [AW-1:0] req_addr,
    input  logic [PW-1:0] req_wdata,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [PW-1:0] rsp_addr,
    output logic          rsp_trap,
    output logic [1:0]    rsp_cause
);

    localparam int LW = AW + 1;

    logic          fire;
    logic [PW-1:0] base_q;
    logic [LW-1:0] limit_q;
    logic [PW-1:0] x_phys;
    logic [1:0]    x_cause;
    logic          x_want_base;
    logic          x_want_limit;

    // A request is taken when it is offered and the output slot has room.
    assign fire = req_valid && req_ready;

    rg_bound_regs #(.PW(PW), .LW(LW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_base  (fire && x_want_base),
        .set_limit (fire && x_want_limit),
        .new_value (req_wdata),
        .base_q    (base_q),
        .limit_q   (limit_q)
    );

    rg_xlate #(.AW(AW), .PW(PW), .LW(LW)) u_xlate (
        .op         (req_op),
        .user       (req_user),
        .addr       (req_addr),
        .base       (base_q),
        .limit      (limit_q),
        .phys       (x_phys),
        .cause      (x_cause),
        .want_base  (x_want_base),
        .want_limit (x_want_limit)
    );

    rg_resp_reg #(.PW(PW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire),
        .in_addr   (x_phys),
        .in_cause  (x_cause),
        .can_take  (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_addr  (rsp_addr),
        .rsp_trap  (rsp_trap),
        .rsp_cause (rsp_cause)
    );

    AST_TRAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_trap == (rsp_cause != 2'd0))); // R9
    AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'd0 && !req_user |=> rsp_valid && !rsp_trap
        && rsp_addr[AW-1:0] == $past(req_addr)); // R4
    AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'd0 && req_user && ({1'b0, req_addr} >= limit_q)
        |=> rsp_trap && rsp_cause == 2'd1 && rsp_addr == '0); // R3
    AST_PRIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_user && (req_op == 2'd1 || req_op == 2'd2)
        |=> $stable(base_q) && $stable(limit_q) && rsp_cause == 2'd2); // R6
    AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'd3 |=> $stable(base_q) && $stable(limit_q)
        && rsp_cause == 2'd3); // R7

endmodule

// File: tb/reloc_guard_bench.sv
// Bench: behavioural reference model compared with the design every cycle.
// Inputs change and outputs are sampled at the falling edge.
module reloc_guard_bench;

    localparam int AW = 16;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic          req_user;
    logic [AW-1:0] req_addr;
    logic [PW-1:0] req_wdata;
    logic          rsp_valid;
    logic          rsp_ready;
    logic [PW-1:0] rsp_addr;
    logic          rsp_trap;
    logic [1:0]    rsp_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    longint m_base;
    longint m_limit;
    bit     m_valid;
    longint m_addr;
    int     m_cause;
    string  m_tag;

    always #10 clk = ~clk;

    reloc_guard #(.AW(AW), .PW(PW)) u_reloc_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_user(req_user), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_trap(rsp_trap), .rsp_cause(rsp_cause)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the outputs with the model, then drive new inputs and advance the model.
    task automatic step(input bit v, input int op, input bit user,
                        input longint addr, input longint wdata, input bit rdy);
        bit accept;
        @(negedge clk);
        check("R8 req_ready", req_ready, (!m_valid || rsp_ready) ? 1 : 0);
        check("R8 rsp_valid", rsp_valid, m_valid);
        if (m_valid) begin
            check({m_tag, " rsp_addr"}, rsp_addr, m_addr);
            check({m_tag, " rsp_cause"}, rsp_cause, m_cause);
            check("R9 rsp_trap", rsp_trap, (m_cause != 0) ? 1 : 0);
        end
        req_valid = v; req_op = op[1:0]; req_user = user;
        req_addr = addr[AW-1:0]; req_wdata = wdata[PW-1:0]; rsp_ready = rdy;
        accept = v && (!m_valid || rdy);
        if (!accept) begin
            if (rdy) m_valid = 0;
        end else begin
            m_valid = 1;
            m_addr = 0;
            m_cause = 0;
            if (op == 3) begin
                m_cause = 3; m_tag = "R7";
            end else if (op != 0 && user) begin
                m_cause = 2; m_tag = "R6";
            end else if (op == 1) begin
                m_base = wdata % (64'd1 << PW); m_tag = "R5";
            end else if (op == 2) begin
                m_limit = wdata % (64'd1 << (AW + 1)); m_tag = "R5";
            end else if (!user) begin
                m_addr = addr % (64'd1 << AW); m_tag = "R4";
            end else if ((addr % (64'd1 << AW)) < m_limit) begin
                m_addr = (m_base + (addr % (64'd1 << AW))) % (64'd1 << PW);
                m_tag = "R2";
            end else begin
                m_cause = 1; m_tag = "R3";
            end
        end
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_op = 0; req_user = 0;
        req_addr = 0; req_wdata = 0; rsp_ready = 1;
        m_base = 0; m_limit = 0; m_valid = 0; m_addr = 0; m_cause = 0; m_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: the reset state at the ports
        @(negedge clk);
        check("R1 rsp_valid after reset", rsp_valid, 0);
        check("R1 req_ready after reset", req_ready, 1);
        // R1: limit 0 after reset, so a user access at 0 traps as out of range
        step(1, 0, 1, 'h0, 0, 1);
        step(1, 1, 0, 0, 'h01000, 1);      // R5: kernel sets base
        step(1, 2, 0, 0, 'h00100, 1);      // R5: kernel sets limit
        step(1, 0, 1, 'h00FF, 0, 1);       // R2: last legal address
        step(1, 0, 1, 'h0100, 0, 1);       // R3: address equal to the limit
        step(1, 0, 1, 'h0101, 0, 1);       // R3: just beyond
        step(1, 0, 0, 'hFFFF, 0, 1);       // R4: kernel access, no check
        step(1, 1, 1, 0, 'h55555, 1);      // R6: user tries to set base
        step(1, 2, 1, 0, 'h0FFFF, 1);      // R6: user tries to set limit
        step(1, 0, 1, 'h0010, 0, 1);       // R6: base and limit still the old values
        step(1, 0, 1, 'h0200, 0, 1);       // R6: limit not widened
        step(1, 3, 0, 0, 'h00000, 1);      // R7: reserved op, kernel mode
        step(1, 3, 1, 0, 'h00000, 1);      // R7: reserved op, user mode
        step(1, 0, 1, 'h0020, 0, 1);       // R7: registers unchanged
        step(1, 1, 0, 0, 'hFFFF0, 1);      // R5: base near the top
        step(1, 2, 0, 0, 'h10000, 1);      // R5: full-window limit
        step(1, 0, 1, 'h0020, 0, 1);       // R2: relocation wraps
        step(1, 0, 1, 'hFFFF, 0, 1);       // R2: top logical address is legal
        // R8: stall with a held response, then drain
        step(1, 0, 0, 'h1234, 0, 0);
        step(1, 0, 0, 'h5678, 0, 0);
        step(1, 0, 0, 'h5678, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        // Mixed traffic with random back-pressure
        for (int i = 0; i < 3000; i++) begin
            int op;
            longint a;
            op = ($urandom % 8 < 5) ? 0 : int'($urandom % 4);
            a = (op == 2) ? longint'($urandom % 'h20000) : longint'($urandom % 'h100000);
            step(($urandom % 4) != 0, op, $urandom % 2, a % 'h10000, a,
                 ($urandom % 3) != 0);
        end
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule